// File: doc/BRIEF.md
# PCI Master Bus Acquisition Sequencer

This block sits between a DMA controller and the PCI bus pins of a network controller. The DMA side presents one access at a time. Each access carries a target (initialization block, descriptor ring, receive buffer or transmit buffer), a direction, a burst flag and a 32-bit address. The sequencer accepts the access, raises the bus request and waits for the arbiter's grant. It does not touch the shared bus until it samples the grant together with an idle bus, meaning no FRAME and no IRDY from any other master.

On the clock after that sample it runs a single address phase. In that clock it drives the address on AD and the bus command on C/BE and asserts FRAME, with no address stepping. One clock later it drives even parity over the address and command. In that same clock it pulses a completion strobe that hands the transfer to the data-phase engine.

Each kind of access maps to exactly one memory command. A configuration input chooses which of the two multi-data read commands serves burst transmit reads. Access kinds that have no meaning are refused at the DMA side.

Top module: `pci_mstr_acq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_req`, `frame_out`, `ad_oe`, `par_oe` and `addr_done` are 0, and `dma_ready` is 1 once out of reset.
- R2: A legal access presented with `dma_valid` while `dma_ready` is 1 is accepted at that clock edge. `bus_req` is 1 in the next cycle and `dma_ready` is 0 until the access is served.
- R3: Once requesting, the block holds `bus_req` at 1 and keeps `frame_out` and `ad_oe` at 0 for as long as no clock edge samples `bus_gnt`=1, `bus_frame_in`=0 and `bus_irdy_in`=0 together. A grant seen while the bus is busy does not start a cycle, and neither does an idle bus seen without a grant.
- R4: In the cycle after the edge that samples grant and an idle bus, `frame_out`=1 and `ad_oe`=1 for exactly one cycle. `ad_out` equals the accepted address and `cbe_out` the selected command in that same cycle.
- R5: Reads of the initialization block or descriptor ring, and non-burst reads of the transmit buffer, use command 4'b0110. Writes to the descriptor ring or receive buffer use 4'b0111. The burst flag is ignored for every target except the transmit buffer. Target codes: 2'b00 initialization block, 2'b01 descriptor ring, 2'b10 receive buffer, 2'b11 transmit buffer. `dma_write`=1 means write.
- R6: Burst reads of the transmit buffer use 4'b1100 when `line_rd_sel` was 0 at acceptance, and 4'b1110 when it was 1.
- R7: In the cycle after the address phase, `par_oe`=1 and `par_out` makes the total count of ones over that phase's `ad_out` and `cbe_out` plus `par_out` even.
- R8: `addr_done` is a one-cycle pulse in the parity cycle. `bus_req` is 0 from the address phase on, and `dma_ready` returns to 1 in the cycle after the pulse.
- R9: The illegal kinds (write to the initialization block, read of the receive buffer, write to the transmit buffer) are not accepted. `bus_req` stays 0 and `dma_ready` stays 1.
- R10: Whenever `frame_out` is 1, `cbe_out` is one of 4'b0110, 4'b0111, 4'b1100, 4'b1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_valid | input | 1 | DMA access present |
| dma_tgt | input | 2 | Access target code |
| dma_write | input | 1 | 1 = write, 0 = read |
| dma_burst | input | 1 | Burst transfer flag |
| dma_addr | input | AW | Start address |
| line_rd_sel | input | 1 | Burst transmit read command choice |
| dma_ready | output | 1 | Sequencer can accept an access |
| bus_req | output | 1 | Bus request to arbiter (active high) |
| bus_gnt | input | 1 | Grant from arbiter (active high) |
| bus_frame_in | input | 1 | FRAME observed on bus (1 = asserted) |
| bus_irdy_in | input | 1 | IRDY observed on bus (1 = asserted) |
| ad_out | output | AW | Address driven in the address phase |
| ad_oe | output | 1 | AD/C/BE output enable |
| cbe_out | output | 4 | Bus command |
| frame_out | output | 1 | FRAME drive (1 = asserted) |
| par_out | output | 1 | Even parity over AD and C/BE |
| par_oe | output | 1 | PAR output enable |
| addr_done | output | 1 | Address phase complete, hand-off strobe |

## Verification
A wrong phase register shows up at once on the pins. It can appear as FRAME driven before an idle grant, FRAME held for two clocks, or a request that is dropped while still waiting. Each of these is visible within one cycle of the faulty transition. A mis-latched address or command appears only in the single address-phase cycle, so the bench samples exactly that cycle for each kind of access. Parity errors surface one clock later, and a stuck phase shows as `dma_ready` never returning after the hand-off strobe.

// File: rtl/pma_pkg.sv
package pma_pkg;

  typedef enum logic [1:0] {
    TGT_INIT  = 2'b00,
    TGT_DESC  = 2'b01,
    TGT_RXBUF = 2'b10,
    TGT_TXBUF = 2'b11
  } tgt_e;

  typedef enum logic [3:0] {
    BC_MEM_RD  = 4'b0110,
    BC_MEM_WR  = 4'b0111,
    BC_RD_MULT = 4'b1100,
    BC_RD_LINE = 4'b1110
  } bus_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_REQ  = 2'b01,
    PH_ADDR = 2'b10,
    PH_PAR  = 2'b11
  } phase_e;

  // which target/direction pairs have a meaning
  function automatic logic access_legal(input tgt_e tgt, input logic wr);
    case (tgt)
      TGT_INIT:  access_legal = !wr;
      TGT_DESC:  access_legal = 1'b1;
      TGT_RXBUF: access_legal = wr;
      default:   access_legal = !wr;
    endcase
  endfunction

  // command for a legal access
  function automatic bus_cmd_e pick_cmd(input tgt_e tgt, input logic wr,
                                        input logic burst, input logic line_sel);
    if (wr)
      pick_cmd = BC_MEM_WR;
    else if (tgt == TGT_TXBUF && burst)
      pick_cmd = line_sel ? BC_RD_LINE : BC_RD_MULT;
    else
      pick_cmd = BC_MEM_RD;
  endfunction

  // even parity bit: xor of all bits
  function automatic logic even_par(input logic [63:0] v, input int n);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < 64; i++)
      if (i < n) acc = acc ^ v[i];
    return acc;
  endfunction

endpackage

// File: rtl/pma_cmd_map.sv
module pma_cmd_map
  import pma_pkg::*;
(
  input  logic [1:0] tgt,
  input  logic       wr,
  input  logic       burst,
  input  logic       line_sel,
  output logic [3:0] cmd,
  output logic       legal
);
  tgt_e tgt_t;
  always_comb begin
    tgt_t = tgt_e'(tgt);
    legal = access_legal(tgt_t, wr);
    cmd   = pick_cmd(tgt_t, wr, burst, line_sel);
  end
endmodule

// File: rtl/pma_par_gen.sv
module pma_par_gen
  import pma_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] data,
  output logic         par_q,
  output logic         par_oe_q
);
  localparam int PADW = 64 - W;
  logic [63:0] wide;
  logic        par_d;

  generate
    if (PADW > 0) begin : g_pad
      assign wide = {{PADW{1'b0}}, data};
    end else begin : g_nopad
      assign wide = data[63:0];
    end
  endgenerate

  always_comb par_d = even_par(wide, W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q    <= 1'b0;
      par_oe_q <= 1'b0;
    end else begin
      par_oe_q <= en;
      par_q    <= en ? par_d : 1'b0;
    end
  end
endmodule

// File: rtl/pma_seq.sv
module pma_seq
  import pma_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_legal,
  input  logic   gnt_i,
  input  logic   frame_i,
  input  logic   irdy_i,
  output phase_e phase,
  output logic   accept,
  output logic   launch
);
  phase_e nxt;
  logic   bus_idle;

  always_comb begin
    bus_idle = !frame_i && !irdy_i;
    accept   = (phase == PH_IDLE) && req_valid && req_legal;
    launch   = (phase == PH_REQ) && gnt_i && bus_idle;
    nxt      = phase;
    case (phase)
      PH_IDLE: if (accept) nxt = PH_REQ;
      PH_REQ:  if (launch) nxt = PH_ADDR;
      PH_ADDR: nxt = PH_PAR;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/pci_mstr_acq.sv
module pci_mstr_acq
  import pma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_valid,
  input  logic [1:0]    dma_tgt,
  input  logic          dma_write,
  input  logic          dma_burst,
  input  logic [AW-1:0] dma_addr,
  input  logic          line_rd_sel,
  output logic          dma_ready,
  output logic          bus_req,
  input  logic          bus_gnt,
  input  logic          bus_frame_in,
  input  logic          bus_irdy_in,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  output logic [3:0]    cbe_out,
  output logic          frame_out,
  output logic          par_out,
  output logic          par_oe,
  output logic          addr_done
);
  localparam int CW = 4;
  localparam int PW = AW + CW;

  // named internal events for the checker
  phase_e          phase;
  logic            accept;
  logic            launch;
  logic            in_addr;
  logic [CW-1:0]   map_cmd;
  logic            map_legal;
  logic [AW-1:0]   addr_q;
  logic [CW-1:0]   cmd_q;

  pma_cmd_map u_map (
    .tgt      (dma_tgt),
    .wr       (dma_write),
    .burst    (dma_burst),
    .line_sel (line_rd_sel),
    .cmd      (map_cmd),
    .legal    (map_legal)
  );

  pma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (dma_valid),
    .req_legal (map_legal),
    .gnt_i     (bus_gnt),
    .frame_i   (bus_frame_in),
    .irdy_i    (bus_irdy_in),
    .phase     (phase),
    .accept    (accept),
    .launch    (launch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (accept) begin
      addr_q <= dma_addr;
      cmd_q  <= map_cmd;
    end
  end

  always_comb begin
    in_addr   = (phase == PH_ADDR);
    dma_ready = (phase == PH_IDLE);
    bus_req   = (phase == PH_REQ);
    frame_out = in_addr;
    ad_oe     = in_addr;
    ad_out    = in_addr ? addr_q : '0;
    cbe_out   = in_addr ? cmd_q : '0;
    addr_done = (phase == PH_PAR);
  end

  pma_par_gen #(.W(PW)) u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (in_addr),
    .data     ({ad_out, cbe_out}),
    .par_q    (par_out),
    .par_oe_q (par_oe)
  );
endmodule

// File: rtl/pci_mstr_acq_chk.sv
module pci_mstr_acq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_frame_in,
  input logic          bus_irdy_in,
  input logic [AW-1:0] ad_out,
  input logic          ad_oe,
  input logic [3:0]    cbe_out,
  input logic          frame_out,
  input logic          par_out,
  input logic          par_oe,
  input logic          addr_done,
  input logic          dma_ready,
  input logic          launch
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!bus_req && !frame_out && !ad_oe && !par_oe && !addr_done));

  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !(bus_gnt && !bus_frame_in && !bus_irdy_in)) |=> (bus_req && !frame_out));

  assert_start_needs_idle_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_out) |-> $past(bus_gnt && !bus_frame_in && !bus_irdy_in && bus_req));

  assert_launch_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (frame_out && ad_oe));

  assert_frame_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_out |=> !frame_out);

  assert_par_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_out |=> (par_oe && (par_out == $past(^{ad_out, cbe_out}))));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |-> (!bus_req && $past(frame_out)) ##1 (!addr_done && dma_ready));

  assert_cmd_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_out |-> (cbe_out == 4'b0110 || cbe_out == 4'b0111 ||
                   cbe_out == 4'b1100 || cbe_out == 4'b1110));
endmodule

bind pci_mstr_acq pci_mstr_acq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_pci_mstr_acq.sv
`timescale 1ns/1ps
module sim_pci_mstr_acq;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dma_valid = 1'b0;
  logic [1:0]    dma_tgt = 2'b00;
  logic          dma_write = 1'b0;
  logic          dma_burst = 1'b0;
  logic [AW-1:0] dma_addr = '0;
  logic          line_rd_sel = 1'b0;
  logic          dma_ready, bus_req;
  logic          bus_gnt = 1'b0;
  logic          bus_frame_in = 1'b0;
  logic          bus_irdy_in = 1'b0;
  logic [AW-1:0] ad_out;
  logic          ad_oe;
  logic [3:0]    cbe_out;
  logic          frame_out, par_out, par_oe, addr_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pci_mstr_acq #(.AW(AW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input logic [1:0] t, input logic w,
                                         input logic b, input logic l);
    if (w) return 4'b0111;
    if (t == 2'b11 && b) return l ? 4'b1110 : 4'b1100;
    return 4'b0110;
  endfunction

  function automatic logic exp_par(input logic [31:0] a, input logic [3:0] c);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += a[i];
    for (int i = 0; i < 4; i++) ones += c[i];
    return (ones % 2) == 1;
  endfunction

  task automatic t_reset();
    chk(!bus_req && !frame_out && !ad_oe && !par_oe && !addr_done, "R1 outputs quiet in reset",
        {bus_req, frame_out, ad_oe, par_oe, addr_done}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(dma_ready == 1'b1 && !bus_req, "R1 ready after reset", {dma_ready, bus_req}, 2'b10);
  endtask

  // one access with busy_n cycles of non-starting bus conditions
  task automatic t_access(input logic [1:0] t, input logic w, input logic b,
                          input logic l, input logic [31:0] a, input int busy_n);
    logic [3:0] ec;
    ec = exp_cmd(t, w, b, l);
    dma_valid = 1'b1; dma_tgt = t; dma_write = w; dma_burst = b;
    dma_addr = a; line_rd_sel = l;
    bus_gnt = 1'b0; bus_frame_in = 1'b1; bus_irdy_in = 1'b1;
    @(negedge clk);
    dma_valid = 1'b0; line_rd_sel = ~l; dma_addr = ~a;
    chk(bus_req && !dma_ready, "R2 request raised", {bus_req, dma_ready}, 2'b10);
    for (int i = 0; i < busy_n; i++) begin
      // alternate: grant with busy bus, then idle bus without grant
      bus_gnt = (i % 2 == 0);
      bus_frame_in = (i % 2 == 0);
      bus_irdy_in = (i % 3 == 0);
      @(negedge clk);
      chk(bus_req && !frame_out && !ad_oe, "R3 waits for idle grant",
          {bus_req, frame_out, ad_oe}, 3'b100);
    end
    bus_gnt = 1'b1; bus_frame_in = 1'b0; bus_irdy_in = 1'b0;
    @(negedge clk);
    bus_gnt = 1'b0;
    chk(frame_out && ad_oe && ad_out == a, "R4 address phase", ad_out, a);
    chk(cbe_out == ec, (w || t != 2'b11 || !b) ? "R5 command" : "R6 burst command",
        cbe_out, ec);
    chk(!bus_req, "R8 request dropped in address phase", bus_req, 0);
    @(negedge clk);
    chk(!frame_out && !ad_oe, "R4 single address cycle", {frame_out, ad_oe}, 0);
    chk(par_oe && par_out == exp_par(a, ec), "R7 parity", {par_oe, par_out},
        {1'b1, exp_par(a, ec)});
    chk(addr_done && !bus_req, "R8 done pulse", {addr_done, bus_req}, 2'b10);
    @(negedge clk);
    chk(!addr_done && dma_ready && !par_oe, "R8 pulse ends, ready",
        {addr_done, dma_ready, par_oe}, 3'b010);
  endtask

  task automatic t_illegal(input logic [1:0] t, input logic w);
    dma_valid = 1'b1; dma_tgt = t; dma_write = w; dma_burst = 1'b0;
    bus_gnt = 1'b1; bus_frame_in = 1'b0; bus_irdy_in = 1'b0;
    @(negedge clk);
    dma_valid = 1'b0;
    chk(!bus_req && dma_ready, "R9 illegal kind refused", {bus_req, dma_ready}, 2'b01);
    @(negedge clk);
    chk(!bus_req && !frame_out && dma_ready, "R9 no cycle started",
        {bus_req, frame_out, dma_ready}, 3'b001);
    bus_gnt = 1'b0;
  endtask

  initial begin
    t_reset();
    t_access(2'b00, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 0);   // init read R5
    t_access(2'b01, 1'b0, 1'b1, 1'b1, 32'h8000_0004, 3);   // desc read, burst ignored R5
    t_access(2'b01, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFF0, 4);   // desc write R5
    t_access(2'b10, 1'b1, 1'b1, 1'b0, 32'h1234_5678, 1);   // rx write R5
    t_access(2'b11, 1'b0, 1'b0, 1'b1, 32'hA5A5_0003, 2);   // tx non-burst R5
    t_access(2'b11, 1'b0, 1'b1, 1'b0, 32'h0F0F_0F00, 5);   // tx burst mult R6
    t_access(2'b11, 1'b0, 1'b1, 1'b1, 32'h7777_7770, 2);   // tx burst line R6
    t_illegal(2'b00, 1'b1);
    t_illegal(2'b10, 1'b0);
    t_illegal(2'b11, 1'b1);
    t_access(2'b11, 1'b0, 1'b1, 1'b1, 32'h0000_0001, 0);   // back-to-back after refusals
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule